// File: doc/BRIEF.md
# Swizzled Vector Operand Fetch and Write-Back Unit

This block sits in the operand and result stage of a four-lane vector shader datapath. Every cycle it decodes a 32-bit instruction word into an opcode, two source register indices, a destination index and a five-bit descriptor id. The descriptor id picks one entry of a 32-entry descriptor table. Each entry holds a per-lane source selector for both operands and a four-bit destination write mask. The unit reads both source vectors without a clock, swizzles them and passes them through a small vector datapath (copy, add, multiply, three- or four-lane dot product). When the execute strobe is high, the result is written at the next rising edge into either the temporary bank or the output scalar bank.

Each scalar is 24 bits wide. The arithmetic is an integer stand-in for the real 24-bit float format: sums and products wrap modulo 2^24. The descriptor table is filled through a small load port. A restart strobe sets its write pointer back to zero, and every data strobe stores one entry and advances the pointer. The uniform bank is filled one whole vector at a time. Lane 0 (x) is always the least significant 24 bits of a vector.

Top module: `vec_operand_unit`

## Requirements
- R1: After reset all output scalars read zero and the error flag is low.
- R2: The instruction fields are opcode [31:26], dest [25:19], src1 [18:12], src2 [11:7] and descriptor id [4:0]. A src1 index of 0x00–0x0F reads input vector n, 0x10–0x1F reads temporary n−0x10, and 0x20–0x7F reads uniform n−0x20.
- R3: A src2 index of 0x00–0x0F reads input vector n and 0x10–0x1F reads temporary n−0x10. No src2 value reaches a uniform.
- R4: Descriptor selectors use 0=x, 1=y, 2=z, 3=w. The src1 selectors for lanes 0..3 sit in bits [12:11], [10:9], [8:7], [6:5]. The src2 selectors for lanes 0..3 sit in bits [21:20], [19:18], [17:16], [15:14].
- R5: Descriptor bits [3:0] are the write mask: bit 3 enables lane x and bit 0 enables lane w. A disabled lane leaves its target unchanged.
- R6: A dest value d in 0x00–0x1B writes lane i to output scalar d+i. A d in 0x40–0x7F writes lane i to temporary scalar d−0x40+i, where temporary t lane c is scalar 4t+c. A lane whose target falls past the end of its bank is dropped, and any other d writes nothing.
- R7: Opcodes are ADD 0x00, DP3 0x01, DP4 0x02, MUL 0x08 and MOV 0x13. MOV copies swizzled src1. ADD and MUL operate per lane modulo 2^24.
- R8: DP3 and DP4 sum the first 3 or 4 lane products modulo 2^24. The scalar result goes only to lanes 0..2 or 0..3 that the mask enables.
- R9: A table restart sets the write pointer to 0. Each data strobe stores one entry and advances the pointer, which wraps from 31 to 0. A restart in the same cycle as a data strobe wins, and that data is discarded.
- R10: Writes take effect at the rising edge on which the execute strobe is high. Without the strobe, no bank changes.
- R11: An opcode outside the five supported ones, when executed, raises the error flag combinationally in that cycle and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word |
| exec_valid | input | 1 | Execute strobe; commits the result at the next edge |
| in_vecs | input | 1536 | Sixteen input vectors, vector n lane c at bits [(4n+c)*24 +: 24] |
| uni_we | input | 1 | Uniform vector write strobe |
| uni_idx | input | 7 | Uniform index; values 96 and above are ignored |
| uni_data | input | 96 | Uniform vector, lane 0 in the low bits |
| tbl_restart | input | 1 | Resets the descriptor table write pointer |
| tbl_wr | input | 1 | Stores tbl_data at the pointer and advances it |
| tbl_data | input | 32 | Descriptor entry |
| out_scalars | output | 672 | 28 output scalars, scalar k at bits [k*24 +: 24] |
| err | output | 1 | Unsupported opcode executed in this cycle |

## Verification
The error flag depends only on the current instruction and strobe, so the bench drives at the falling edge and samples it one nanosecond later, before any clock edge. Bank writes land at the rising edge that follows, so outputs are compared at the next falling edge. Temporaries are checked by later instructions that copy them out. A table entry stored at one edge can first be used by an instruction in the following cycle, and the bench only runs instructions after its table loads have finished. A reference model in the bench follows the field positions and arithmetic stated above, and every output scalar is compared after every instruction.

// File: rtl/vou_pkg.sv
package vou_pkg;
    localparam int SCALAR_W = 24;
    localparam int LANES    = 4;

    localparam logic [5:0] OP_ADD = 6'h00;
    localparam logic [5:0] OP_DP3 = 6'h01;
    localparam logic [5:0] OP_DP4 = 6'h02;
    localparam logic [5:0] OP_MUL = 6'h08;
    localparam logic [5:0] OP_MOV = 6'h13;

    typedef logic [LANES-1:0][SCALAR_W-1:0] vec_t;
endpackage

// File: rtl/vou_desc_table.sv
module vou_desc_table #(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             wr_i,
    input  logic [31:0]      data_i,
    input  logic [PTR_W-1:0] rd_idx_i,
    output logic [31:0]      rd_desc_o,
    output logic [PTR_W-1:0] ptr_o
);
    typedef struct packed {
        logic [PTR_W-1:0]            ptr;
        logic [DEPTH-1:0][31:0]      ent;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.ptr = '0;
        end else if (wr_i) begin
            st_d.ent[st_q.ptr] = data_i;
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_desc_o = st_q.ent[rd_idx_i];
    assign ptr_o     = st_q.ptr;
endmodule

// File: rtl/vou_src_sel.sv
module vou_src_sel
    import vou_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int N_IN  = 16,
    parameter int N_TMP = 16,
    parameter int N_UNI = 96
) (
    input  logic [IDX_W-1:0]             idx_i,
    input  logic [7:0]                   sel_i,
    input  vec_t [N_IN-1:0]              in_i,
    input  vec_t [N_TMP-1:0]             tmp_i,
    input  vec_t [N_UNI-1:0]             uni_i,
    output vec_t                         vec_o
);
    localparam int TMP_LO = N_IN;
    localparam int UNI_LO = N_IN + N_TMP;

    vec_t raw;

    always_comb begin
        raw = '0;
        for (int k = 0; k < N_IN; k++)
            if (int'(idx_i) == k) raw = in_i[k];
        for (int k = 0; k < N_TMP; k++)
            if (int'(idx_i) == TMP_LO + k) raw = tmp_i[k];
        for (int k = 0; k < N_UNI; k++)
            if (int'(idx_i) == UNI_LO + k) raw = uni_i[k];
    end

    // lane 0 selector in the top pair of sel_i, lane 3 in the bottom pair
    for (genvar c = 0; c < LANES; c++) begin : g_lane
        assign vec_o[c] = raw[sel_i[7-2*c -: 2]];
    end
endmodule

// File: rtl/vou_alu.sv
module vou_alu
    import vou_pkg::*;
(
    input  logic [5:0] op_i,
    input  vec_t       a_i,
    input  vec_t       b_i,
    output vec_t       res_o,
    output logic [2:0] lanes_o,
    output logic       ok_o
);
    logic [SCALAR_W-1:0] acc;

    always_comb begin
        res_o   = '0;
        lanes_o = 3'd4;
        ok_o    = 1'b1;
        acc     = '0;
        case (op_i)
            OP_MOV: res_o = a_i;
            OP_ADD: for (int c = 0; c < LANES; c++) res_o[c] = a_i[c] + b_i[c];
            OP_MUL: for (int c = 0; c < LANES; c++) res_o[c] = a_i[c] * b_i[c];
            OP_DP3, OP_DP4: begin
                lanes_o = (op_i == OP_DP3) ? 3'd3 : 3'd4;
                for (int c = 0; c < LANES; c++)
                    if (c < int'(lanes_o)) acc = acc + a_i[c] * b_i[c];
                for (int c = 0; c < LANES; c++) res_o[c] = acc;
            end
            default: ok_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/vec_operand_unit.sv
module vec_operand_unit
    import vou_pkg::*;
#(
    parameter int N_IN     = 16,
    parameter int N_TMP    = 16,
    parameter int N_UNI    = 96,
    parameter int N_OUT    = 28,
    parameter int TBL_SIZE = 32,
    localparam int W        = SCALAR_W,
    localparam int TMP_SCL  = N_TMP * LANES,
    localparam int DST_TMP  = 64,
    localparam int PTR_W    = $clog2(TBL_SIZE)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [31:0]                instr,
    input  logic                       exec_valid,
    input  logic [N_IN*LANES*W-1:0]    in_vecs,
    input  logic                       uni_we,
    input  logic [6:0]                 uni_idx,
    input  logic [LANES*W-1:0]         uni_data,
    input  logic                       tbl_restart,
    input  logic                       tbl_wr,
    input  logic [31:0]                tbl_data,
    output logic [N_OUT*W-1:0]         out_scalars,
    output logic                       err
);
    typedef struct packed {
        vec_t [N_UNI-1:0]               uni;
        logic [TMP_SCL-1:0][W-1:0]      tmp;
        logic [N_OUT-1:0][W-1:0]        outs;
    } bank_t;

    bank_t st_d, st_q;

    logic [5:0]       f_op;
    logic [6:0]       f_dest;
    logic [6:0]       f_src1;
    logic [4:0]       f_src2;
    logic [PTR_W-1:0] f_did;
    logic [31:0]      desc;
    logic [PTR_W-1:0] tab_ptr;
    vec_t [N_IN-1:0]  in_arr;
    vec_t [N_TMP-1:0] tmp_arr;
    vec_t             opa, opb, alu_res;
    logic [2:0]       alu_lanes;
    logic             alu_ok;
    logic             unused_bits;

    assign f_op   = instr[31:26];
    assign f_dest = instr[25:19];
    assign f_src1 = instr[18:12];
    assign f_src2 = instr[11:7];
    assign f_did  = instr[PTR_W-1:0];
    assign unused_bits = ^{instr[6:5], desc[31:22], desc[13], desc[4]};

    assign in_arr  = in_vecs;
    assign tmp_arr = st_q.tmp;

    vou_desc_table #(.DEPTH(TBL_SIZE)) u_tbl (
        .clk(clk), .rst_n(rst_n), .restart_i(tbl_restart), .wr_i(tbl_wr),
        .data_i(tbl_data), .rd_idx_i(f_did), .rd_desc_o(desc), .ptr_o(tab_ptr)
    );

    vou_src_sel #(.IDX_W(7), .N_IN(N_IN), .N_TMP(N_TMP), .N_UNI(N_UNI)) u_src1 (
        .idx_i(f_src1), .sel_i(desc[12:5]), .in_i(in_arr), .tmp_i(tmp_arr),
        .uni_i(st_q.uni), .vec_o(opa)
    );

    vou_src_sel #(.IDX_W(5), .N_IN(N_IN), .N_TMP(N_TMP), .N_UNI(N_UNI)) u_src2 (
        .idx_i(f_src2), .sel_i(desc[21:14]), .in_i(in_arr), .tmp_i(tmp_arr),
        .uni_i(st_q.uni), .vec_o(opb)
    );

    vou_alu u_alu (
        .op_i(f_op), .a_i(opa), .b_i(opb), .res_o(alu_res),
        .lanes_o(alu_lanes), .ok_o(alu_ok)
    );

    always_comb begin
        st_d = st_q;
        if (uni_we) begin
            for (int u = 0; u < N_UNI; u++)
                if (int'(uni_idx) == u) st_d.uni[u] = uni_data;
        end
        if (exec_valid && alu_ok) begin
            for (int c = 0; c < LANES; c++) begin
                if (desc[3-c] && (c < int'(alu_lanes))) begin
                    if (int'(f_dest) < N_OUT) begin
                        for (int k = 0; k < N_OUT; k++)
                            if (int'(f_dest) + c == k) st_d.outs[k] = alu_res[c];
                    end else if (int'(f_dest) >= DST_TMP) begin
                        for (int k = 0; k < TMP_SCL; k++)
                            if (int'(f_dest) - DST_TMP + c == k) st_d.tmp[k] = alu_res[c];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_scalars = st_q.outs;
    assign err         = exec_valid && !alu_ok;
endmodule

// File: rtl/vec_operand_unit_chk.sv
module vec_operand_unit_chk #(
    parameter int OUT_BITS = 672
) (
    input logic                clk,
    input logic                rst_n,
    input logic [31:0]         instr,
    input logic                exec_valid,
    input logic                err,
    input logic                tbl_restart,
    input logic                tbl_wr,
    input logic [4:0]          tab_ptr,
    input logic [OUT_BITS-1:0] out_scalars
);
    AST_ERR_NEEDS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> exec_valid); // R11
    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> $stable(out_scalars)); // R11
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid |=> $stable(out_scalars)); // R10
    AST_HIGH_DEST_SPARES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && instr[25:19] >= 7'h1C) |=> $stable(out_scalars)); // R6
    AST_RESTART_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_restart |=> (tab_ptr == 5'd0)); // R9
    AST_WRITE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_wr && !tbl_restart) |=> (tab_ptr == 5'($past(tab_ptr) + 5'd1))); // R9
    AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tbl_wr && !tbl_restart) |=> $stable(tab_ptr)); // R9
endmodule

bind vec_operand_unit vec_operand_unit_chk #(.OUT_BITS(N_OUT*W)) u_chk (.*);

// File: tb/vec_operand_unit_test.sv
module vec_operand_unit_test;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     instr = '0;
    logic            exec_valid = 1'b0;
    logic [1535:0]   in_vecs = '0;
    logic            uni_we = 1'b0;
    logic [6:0]      uni_idx = '0;
    logic [95:0]     uni_data = '0;
    logic            tbl_restart = 1'b0;
    logic            tbl_wr = 1'b0;
    logic [31:0]     tbl_data = '0;
    logic [671:0]    out_scalars;
    logic            err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [23:0] m_in [16][4];
    logic [23:0] m_uni[96][4];
    logic [23:0] m_tmp[64];
    logic [23:0] m_out[28];
    logic [31:0] m_desc[32];
    int          m_ptr = 0;

    vec_operand_unit uut (.*);

    always #4 clk = ~clk;

    function automatic logic [31:0] pat_desc(int k);
        logic [31:0] d = '0;
        d[3:0] = (k == 0) ? 4'hF : 4'(k % 16);
        for (int i = 0; i < 4; i++) begin
            d[12-2*i -: 2] = 2'((k + i) % 4);
            d[21-2*i -: 2] = 2'((3 * k + i + 1) % 4);
        end
        return d;
    endfunction

    function automatic logic [23:0] fetch(int idx, int lane, bit first);
        if (idx < 16) return m_in[idx][lane];
        if (idx < 32 || !first) return m_tmp[(idx - 16) * 4 + lane];
        return m_uni[idx - 32][lane];
    endfunction

    task automatic check(bit ok, string req, logic [671:0] act, logic [671:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmp_out(string req);
        logic [671:0] e;
        for (int k = 0; k < 28; k++) e[k*24 +: 24] = m_out[k];
        check(out_scalars === e, req, out_scalars, e);
    endtask

    task automatic tbl_put(logic [31:0] data, bit rs, bit wr);
        @(negedge clk);
        tbl_data = data; tbl_restart = rs; tbl_wr = wr;
        if (rs) m_ptr = 0;
        else if (wr) begin m_desc[m_ptr] = data; m_ptr = (m_ptr + 1) % 32; end
        @(negedge clk);
        tbl_restart = 0; tbl_wr = 0;
    endtask

    task automatic run(logic [5:0] op, int dest, int s1, int s2, int did, bit go, string req);
        logic [23:0] a[4], b[4], r[4];
        logic [31:0] d;
        logic [23:0] acc;
        int n;
        bit ok;
        d = m_desc[did];
        for (int i = 0; i < 4; i++) begin
            a[i] = fetch(s1, int'(d[12-2*i -: 2]), 1);
            b[i] = fetch(s2 % 32, int'(d[21-2*i -: 2]), 0);
        end
        n = 4; ok = 1; acc = '0;
        case (op)
            6'h13: for (int i = 0; i < 4; i++) r[i] = a[i];
            6'h00: for (int i = 0; i < 4; i++) r[i] = a[i] + b[i];
            6'h08: for (int i = 0; i < 4; i++) r[i] = 24'(a[i] * b[i]);
            6'h01, 6'h02: begin
                n = (op == 6'h01) ? 3 : 4;
                for (int i = 0; i < n; i++) acc = acc + 24'(a[i] * b[i]);
                for (int i = 0; i < 4; i++) r[i] = acc;
            end
            default: begin ok = 0; for (int i = 0; i < 4; i++) r[i] = '0; end
        endcase
        if (go && ok) begin
            for (int i = 0; i < 4; i++) begin
                if (d[3-i] && i < n) begin
                    if (dest < 28) begin
                        if (dest + i < 28) m_out[dest+i] = r[i];
                    end else if (dest >= 64) begin
                        if (dest - 64 + i < 64) m_tmp[dest-64+i] = r[i];
                    end
                end
            end
        end
        @(negedge clk);
        instr = {op, 7'(dest), 7'(s1), 5'(s2), 2'b00, 5'(did)};
        exec_valid = go;
        #1;
        check(err === (go && !ok), {req, " err"}, {671'd0, err}, {671'd0, go && !ok});
        @(negedge clk);
        exec_valid = 0;
        cmp_out(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++)
            for (int c = 0; c < 4; c++) begin
                m_in[i][c] = 24'h200000 | 24'(i * 16 + c + 3);
                in_vecs[(i*4+c)*24 +: 24] = m_in[i][c];
            end
        for (int k = 0; k < 64; k++) m_tmp[k] = '0;
        for (int k = 0; k < 28; k++) m_out[k] = '0;
        for (int k = 0; k < 32; k++) m_desc[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        cmp_out("R1 reset outputs");
        check(err === 1'b0, "R1 reset err", {671'd0, err}, 672'd0);
        rst_n = 1;

        for (int u = 0; u < 96; u++) begin
            @(negedge clk);
            uni_we = 1; uni_idx = 7'(u);
            for (int c = 0; c < 4; c++) begin
                m_uni[u][c] = 24'h100000 | 24'(u * 256 + c * 7 + 1);
                uni_data[c*24 +: 24] = m_uni[u][c];
            end
        end
        @(negedge clk); uni_we = 0;

        // R9: 33 stores after restart, the last wraps onto entry 0
        tbl_put('0, 1, 0);
        tbl_put(32'h0000_0000, 0, 1);
        for (int j = 1; j < 32; j++) tbl_put(pat_desc(j), 0, 1);
        tbl_put(pat_desc(0), 0, 1);

        // fill temporaries from inputs (R6 temp targets, R2 input reads)
        for (int t = 0; t < 16; t++) run(6'h13, 64 + 4 * t, 15 - t, 0, 0, 1, "R6 temp fill");
        // R2: every src1 index
        for (int s = 0; s < 128; s++) run(6'h13, (s % 7) * 4, s, 0, 0, 1, "R2 src1 sweep");
        // R3: every src2 index
        for (int s = 0; s < 32; s++) run(6'h00, 0, 32 + s, s, 0, 1, "R3 src2 sweep");
        // R4 R5 R7: every descriptor with MUL and ADD
        for (int k = 0; k < 32; k++) run(6'h08, 4, 37 + k, 19, k, 1, "R4 R5 R7 mul desc sweep");
        for (int k = 0; k < 32; k++) run(6'h00, 12, 5, 20 + (k % 12), k, 1, "R4 R7 add desc sweep");
        // R8: dot products under every mask
        for (int k = 0; k < 32; k++) begin
            run(6'h01, 8, 40 + k, k % 32, k, 1, "R8 dp3");
            run(6'h02, 16, 70 + k, 31 - k, k, 1, "R8 dp4");
        end
        // R6: every destination value
        for (int d = 0; d < 128; d++) run(6'h13, d, 48 + (d % 16), 0, 0, 1, "R6 dest sweep");
        for (int t = 0; t < 16; t++) run(6'h13, (t % 7) * 4, 16 + t, 0, 0, 1, "R6 temp readback");
        // R10: no strobe, no write
        run(6'h13, 0, 100, 0, 0, 0, "R10 idle");
        run(6'h00, 72, 3, 4, 0, 0, "R10 idle temp");
        run(6'h13, 4, 20, 0, 0, 1, "R10 idle temp readback");
        // R11: unsupported opcodes
        run(6'h21, 0, 33, 0, 0, 1, "R11 bad op 0x21");
        run(6'h03, 64, 33, 0, 0, 1, "R11 bad op 0x03");
        run(6'h3F, 8, 34, 1, 0, 1, "R11 bad op 0x3F");
        run(6'h3F, 8, 34, 1, 0, 0, "R11 bad op idle");
        run(6'h13, 8, 16, 0, 0, 1, "R11 temp untouched");

        // R9: restart priority over a same-cycle store
        tbl_put('0, 1, 0);
        tbl_put(pat_desc(5), 0, 1);
        tbl_put(pat_desc(7), 0, 1);
        tbl_put(pat_desc(9), 1, 1);
        tbl_put(pat_desc(0), 0, 1);
        run(6'h13, 20, 50, 0, 1, 1, "R9 entry1 kept");
        run(6'h13, 24, 51, 0, 0, 1, "R9 entry0 rewritten");
        run(6'h00, 0, 60, 6, 2, 1, "R9 entry2 untouched");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule